// File: doc/BRIEF.md
# Timed Sensor Register Access Engine

This block is an SPI master front end that carries out single-register reads and writes to an optical motion sensor. A host raises `req_valid` with a 7-bit register address, a write flag and a data byte. The engine then runs one 16-clock frame. The first byte carries the direction in its top bit followed by the address. The second byte is either the write data going out or the register contents coming back.

The sensor requires fixed gaps around each access. The engine keeps chip select asserted for a hold period after the last clock, then waits through a turnaround gap before it accepts the next request. Writes use longer periods than reads. Every period is a count of microseconds multiplied by the `CLKS_PER_US` parameter. `done` pulses once at the end of the gap, and a read returns its byte on `rd_data` in that same cycle.

The engine also keeps a flag for the sensor's burst mode. Writing the burst register (address 0x50) sets the flag, and a write to any other address clears it.

Top module: `sensor_spi_access`

## Requirements
- R1: A write frame shifts out 16 bits MSB first: a 1, then the 7-bit address, then the 8 data bits, over exactly 16 SCLK pulses.
- R2: A read frame shifts out a 0, then the 7-bit address, then eight 0 bits. MISO is sampled on the 8 rising SCLK edges of the second byte, MSB first, and the resulting byte is shown on `rd_data` during the `done` cycle.
- R3: SPI mode 3 is used. SCLK is high whenever chip select is deasserted, and MOSI changes only in the cycle in which SCLK falls.
- R4: The first falling SCLK edge comes exactly SETUP_US×CLKS_PER_US cycles after chip select asserts.
- R5: After a write, chip select deasserts WR_HOLD_US×CLKS_PER_US cycles after the last rising SCLK edge, and busy falls WR_GAP_US×CLKS_PER_US cycles after that.
- R6: After a read, chip select deasserts RD_HOLD_US×CLKS_PER_US cycles after the last rising SCLK edge, and busy falls RD_GAP_US×CLKS_PER_US cycles after that.
- R7: Busy is high from the cycle after a request is accepted until the trailing gap ends. A request raised while busy has no effect: the frame in progress is unchanged, the burst flag is unchanged, and no frame follows.
- R8: `done` is a single-cycle pulse in the cycle in which busy falls. `rd_data` is zero in every other cycle and is also zero in the `done` cycle of a write.
- R9: When a write is accepted, `burst_active` becomes 1 if the address is 0x50 and 0 otherwise, and is visible from the first busy cycle. Reads leave it unchanged.
- R10: Reset gives chip select high, SCLK high, and busy, done, rd_data and burst_active all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress, including the trailing gap |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read byte, valid only while done is high |
| burst_active | output | 1 | Burst-mode flag |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
Four properties are checked on every cycle: SCLK idles high whenever chip select is released, MOSI moves only on a falling SCLK, `done` appears only at the falling edge of busy, and the burst flag changes only in the cycle in which a request is accepted. The exact cycle counts of the setup, hold and gap intervals, the bit contents of each frame, and the byte returned from MISO can only be shown by the bench. It sweeps every address for both directions and measures each interval against counts it computes itself. The same applies to showing that a request raised mid-transaction leaves no trace.

// File: rtl/sensor_spi_pkg.sv
package sensor_spi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } eng_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_interval_timer.sv
// Down-counter used for every timed interval of the access engine.
module spi_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/spi_frame_shifter.sv
// Mode-3 frame shifter: SCLK idles high, MOSI changes on the falling edge,
// MISO is captured as SCLK rises.
module spi_frame_shifter #(
  parameter int FRAME_W = 16,
  parameter int HALF    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx_word,
  output logic               fin
);

  localparam int PC_W = $clog2(HALF + 1);
  localparam int BC_W = $clog2(FRAME_W + 1);

  logic               active;
  logic               phase_hi;
  logic [PC_W-1:0]    pcnt;
  logic [BC_W-1:0]    bcnt;
  logic [FRAME_W-1:0] tx_sh;

  // strobe at the end of the final high phase
  assign fin = active && phase_hi && (pcnt == '0) && (bcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      phase_hi <= 1'b0;
      pcnt     <= '0;
      bcnt     <= '0;
      sclk     <= 1'b1;
      mosi     <= 1'b0;
      tx_sh    <= '0;
      rx_word  <= '0;
    end else if (start) begin
      active   <= 1'b1;
      phase_hi <= 1'b0;
      sclk     <= 1'b0;
      mosi     <= tx_word[FRAME_W-1];
      tx_sh    <= tx_word << 1;
      pcnt     <= PC_W'(HALF - 1);
      bcnt     <= BC_W'(FRAME_W - 1);
      rx_word  <= '0;
    end else if (active) begin
      if (!phase_hi) begin
        if (pcnt == '0) begin
          sclk     <= 1'b1;
          rx_word  <= {rx_word[FRAME_W-2:0], miso};
          phase_hi <= 1'b1;
          pcnt     <= PC_W'(HALF - 1);
        end else begin
          pcnt <= pcnt - 1'b1;
        end
      end else begin
        if (pcnt == '0) begin
          if (bcnt == '0) begin
            active <= 1'b0;
          end else begin
            sclk     <= 1'b0;
            mosi     <= tx_sh[FRAME_W-1];
            tx_sh    <= tx_sh << 1;
            bcnt     <= bcnt - 1'b1;
            phase_hi <= 1'b0;
            pcnt     <= PC_W'(HALF - 1);
          end
        end else begin
          pcnt <= pcnt - 1'b1;
        end
      end
    end
  end

  // R3: data line moves only together with a falling clock
  assert_mosi_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> $fell(sclk));

endmodule

// File: rtl/sensor_spi_access.sv
module sensor_spi_access
  import sensor_spi_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int SCLK_HALF   = 4,
  parameter int SETUP_US    = 1,
  parameter int WR_HOLD_US  = 20,
  parameter int WR_GAP_US   = 100,
  parameter int RD_HOLD_US  = 1,
  parameter int RD_GAP_US   = 19,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] BURST_REG = 'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              burst_active,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int FRAME_W     = 1 + ADDR_W + DATA_W;
  localparam int SETUP_CYC   = SETUP_US * CLKS_PER_US;
  localparam int WR_HOLD_CYC = WR_HOLD_US * CLKS_PER_US;
  localparam int WR_GAP_CYC  = WR_GAP_US * CLKS_PER_US;
  localparam int RD_HOLD_CYC = RD_HOLD_US * CLKS_PER_US;
  localparam int RD_GAP_CYC  = RD_GAP_US * CLKS_PER_US;
  // hold counted from the last rising SCLK; the final high phase already spent SCLK_HALF
  localparam int WR_HOLD_LD  = WR_HOLD_CYC - SCLK_HALF - 1;
  localparam int RD_HOLD_LD  = RD_HOLD_CYC - SCLK_HALF - 1;
  localparam int MAX_CYC     = imax(imax(SETUP_CYC, WR_HOLD_CYC),
                                    imax(imax(WR_GAP_CYC, RD_HOLD_CYC), RD_GAP_CYC));
  localparam int TMR_W       = $clog2(MAX_CYC + 1);

  eng_state_t         state;
  logic               is_wr;
  logic [FRAME_W-1:0] tx_word;
  logic               accept;
  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_val;
  logic               tmr_exp;
  logic               sh_start;
  logic               sh_fin;
  logic [FRAME_W-1:0] sh_rx;

  assign accept   = (state == ST_IDLE) && req_valid;
  assign sh_start = (state == ST_SETUP) && tmr_exp;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: begin
        tmr_load = req_valid;
        tmr_val  = TMR_W'(SETUP_CYC - 1);
      end
      ST_SHIFT: begin
        tmr_load = sh_fin;
        tmr_val  = is_wr ? TMR_W'(WR_HOLD_LD) : TMR_W'(RD_HOLD_LD);
      end
      ST_HOLD: begin
        tmr_load = tmr_exp;
        tmr_val  = is_wr ? TMR_W'(WR_GAP_CYC - 1) : TMR_W'(RD_GAP_CYC - 1);
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  spi_interval_timer #(
    .CNT_W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  spi_frame_shifter #(
    .FRAME_W (FRAME_W),
    .HALF    (SCLK_HALF)
  ) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .start   (sh_start),
    .tx_word (tx_word),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .rx_word (sh_rx),
    .fin     (sh_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      is_wr        <= 1'b0;
      tx_word      <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      rd_data      <= '0;
      burst_active <= 1'b0;
      spi_cs_n     <= 1'b1;
    end else begin
      done    <= 1'b0;
      rd_data <= '0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            busy     <= 1'b1;
            spi_cs_n <= 1'b0;
            is_wr    <= req_write;
            tx_word  <= {req_write, req_addr, (req_write ? req_wdata : {DATA_W{1'b0}})};
            if (req_write) begin
              burst_active <= (req_addr == BURST_REG);
            end
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tmr_exp) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (sh_fin) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (tmr_exp) begin
            spi_cs_n <= 1'b1;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tmr_exp) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rd_data <= is_wr ? {DATA_W{1'b0}} : sh_rx[DATA_W-1:0];
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: clock parked high while the sensor is deselected
  assert_sclk_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> spi_sclk);

  // R8: completion only where busy drops
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8: busy never drops without the completion pulse
  assert_busy_fall_has_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: burst flag moves only at request acceptance
  assert_burst_on_accept_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(burst_active) |-> $rose(busy));

  // R7: a busy cycle is followed by busy or by the completion pulse
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

endmodule

// File: tb/sensor_spi_access_bench.sv
module sensor_spi_access_bench;

  localparam int CPU    = 2;
  localparam int HALF   = 1;
  localparam int E_SET  = 1 * CPU;
  localparam int E_WH   = 20 * CPU;
  localparam int E_WG   = 100 * CPU;
  localparam int E_RH   = 1 * CPU;
  localparam int E_RG   = 19 * CPU;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       busy, done, burst_active;
  logic [7:0] rd_data;
  logic       spi_cs_n, spi_sclk, spi_mosi;
  logic       spi_miso = 1'b0;

  int  cyc = 0;
  int  tests = 0;
  int  fails = 0;
  bit  model_burst = 1'b0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sensor_spi_access #(
    .CLKS_PER_US (CPU),
    .SCLK_HALF   (HALF)
  ) u_sensor_spi_access (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .busy         (busy),
    .done         (done),
    .rd_data      (rd_data),
    .burst_active (burst_active),
    .spi_cs_n     (spi_cs_n),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .spi_miso     (spi_miso)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [6:0] a, input logic [7:0] d,
                         input logic [7:0] resp, input bit poke);
    int t_csf = -1, t_ff = -1, t_lr = -1, t_csr = -1, t_bf = -1;
    int nb = 0;
    logic [15:0] word = '0;
    logic [15:0] exp_word;
    logic [7:0] got = '0;
    bit pcs, psclk, pmosi, pbusy;
    bit seen_done = 1'b0;
    bit shape_bad = 1'b0;
    logic [6:0] poke_addr;
    string rq_tail;
    rq_tail = wr ? "R5" : "R6";
    @(negedge clk);
    pcs = spi_cs_n; psclk = spi_sclk; pmosi = spi_mosi; pbusy = busy;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    if (wr) model_burst = (a == 7'h50);
    chk(burst_active == model_burst, "R9", "burst flag after accept", burst_active, model_burst);
    poke_addr = model_burst ? 7'h11 : 7'h50;
    for (int k = 0; k < 4000; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == 9) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = poke_addr; req_wdata = 8'hFF;
      end else if (poke && k == 10) begin
        req_valid = 1'b0;
      end
      if (pcs && !spi_cs_n) t_csf = cyc;
      if (!pcs && spi_cs_n) t_csr = cyc;
      if (psclk && !spi_sclk) begin
        if (t_ff < 0) t_ff = cyc;
        if (nb >= 8 && nb < 16) spi_miso = resp[15-nb];
      end
      if (!psclk && spi_sclk) begin
        word = {word[14:0], spi_mosi};
        nb++;
        t_lr = cyc;
      end
      if ((spi_mosi != pmosi) && !(psclk && !spi_sclk)) shape_bad = 1'b1;
      if (spi_cs_n && !spi_sclk) shape_bad = 1'b1;
      if (pbusy && !busy) t_bf = cyc;
      if (done) begin
        got = rd_data;
        seen_done = 1'b1;
        chk(!busy && pbusy, "R8", "done coincides with busy fall", busy, 0);
        break;
      end
      pcs = spi_cs_n; psclk = spi_sclk; pmosi = spi_mosi; pbusy = busy;
    end
    // the accept edge itself was seen on the first loop sample
    if (t_csf < 0) t_csf = cyc;
    exp_word = {wr, a, (wr ? d : 8'h00)};
    chk(seen_done, "R8", "done pulse seen", seen_done, 1);
    chk(nb == 16, wr ? "R1" : "R2", "sclk pulses", nb, 16);
    chk(word == exp_word, wr ? "R1" : "R2", "frame bits", word, exp_word);
    chk(t_ff - t_csf == E_SET, "R4", "cs to first fall", t_ff - t_csf, E_SET);
    chk(t_csr - t_lr == (wr ? E_WH : E_RH), rq_tail, "hold", t_csr - t_lr, wr ? E_WH : E_RH);
    chk(t_bf - t_csr == (wr ? E_WG : E_RG), rq_tail, "gap", t_bf - t_csr, wr ? E_WG : E_RG);
    chk(got == (wr ? 8'h00 : resp), wr ? "R8" : "R2", "rd_data at done", got, wr ? 0 : resp);
    chk(!shape_bad, "R3", "mode 3 waveform", shape_bad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    chk(rd_data == 8'h00, "R8", "rd_data idle zero", rd_data, 0);
    if (poke) begin
      for (int j = 0; j < 6; j++) begin
        chk(spi_cs_n && !busy, "R7", "no frame from ignored request", busy, 0);
        @(negedge clk);
      end
      chk(burst_active == model_burst, "R7", "burst untouched by ignored request",
          burst_active, model_burst);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(spi_cs_n == 1'b1, "R10", "cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b1, "R10", "sclk", spi_sclk, 1);
    chk(busy == 1'b0, "R10", "busy", busy, 0);
    chk(done == 1'b0, "R10", "done", done, 0);
    chk(rd_data == 8'h00, "R10", "rd_data", rd_data, 0);
    chk(burst_active == 1'b0, "R10", "burst_active", burst_active, 0);

    // R9 ordering: set, reads keep it, other write clears, set again
    run_txn(1'b1, 7'h50, 8'h00, 8'h00, 1'b0);
    run_txn(1'b0, 7'h50, 8'h00, 8'h3C, 1'b0);
    run_txn(1'b0, 7'h02, 8'h00, 8'hC3, 1'b0);
    run_txn(1'b1, 7'h0F, 8'h07, 8'h00, 1'b0);
    run_txn(1'b1, 7'h50, 8'h00, 8'h00, 1'b0);

    // R2 sweep of all addresses for reads, burst flag held at 1
    for (int i = 0; i < 128; i++)
      run_txn(1'b0, 7'(i), 8'h00, 8'((i * 91) ^ 8'hA5), 1'b0);

    // R1 sweep of all addresses for writes, flag tracked per write
    for (int i = 0; i < 128; i++)
      run_txn(1'b1, 7'(i), 8'((i * 37) + 5), 8'h00, 1'b0);

    // R7 requests raised while busy
    run_txn(1'b1, 7'h22, 8'h81, 8'h00, 1'b1);
    run_txn(1'b0, 7'h7F, 8'h00, 8'hFF, 1'b1);
    run_txn(1'b1, 7'h50, 8'h00, 8'h00, 1'b1);

    summary();
  end

endmodule